// File: doc/BRIEF.md
# Supervisory Reset Pulse Stretcher

This block generates the system reset for a processor supervisor. It takes a digital supply-good flag from an external threshold comparator and an active-low manual reset request. It drives a pair of complementary reset outputs. Reset is held while the supply flag reports a bad supply or while the manual request is held low. When both causes have cleared, the outputs stay asserted for a further fixed stretch time. The nominal stretch time is 200 ms, and it must stay within 140 ms to 280 ms of wall time.

Both inputs are asynchronous, so each passes through a two-flop synchroniser. The manual request then goes through a low-pulse qualifier. The qualifier accepts a request only after the request has stayed low for a minimum number of consecutive clocks, set by a minimum pulse width in nanoseconds (nominally 150 ns). The stretch length and the qualifier length are both derived from the clock frequency parameter. If either cause returns while the stretch is running, the stretch count reloads, and the full stretch restarts once both causes have cleared again.

Top module: `sup_reset_gen`

## Requirements
- R1: While `supply_ok_i` is low, `rst_n_o` is low: it is low at every rising edge that comes three or more edges after an edge that sampled `supply_ok_i` low.
- R2: A manual request held low for at least FILT consecutive clock samples drives `rst_n_o` low. FILT = ceil(CLK_HZ*MR_MIN_NS/1e9), with a minimum of 1.
- R3: After `supply_ok_i` returns high with the manual request idle, `rst_n_o` rises exactly at rising edge S+3. The first edge that samples `supply_ok_i` high counts as edge 1. This is two synchroniser stages, S stretch cycles and one output register.
- R4: After a qualified manual request is released (`mr_n_i` goes back high) with the supply good, `rst_n_o` rises exactly at rising edge S+4. The first edge that samples `mr_n_i` high counts as edge 1.
- R5: The stretch length is S = CLK_HZ*STRETCH_US/1e6 clock cycles. The defaults of 50 MHz and 200000 us give 200 ms.
- R6: `rst_o` is at all times the logical inverse of `rst_n_o`.
- R7: A manual low pulse shorter than FILT samples is ignored. `rst_n_o` stays high throughout and after such a pulse.
- R8: If either cause reappears during a stretch, the count reloads. The rise then follows R3 or R4, measured from the last cause to clear.
- R9: While `rst_i` is high, and right after it is released, the outputs are asserted (`rst_n_o` low, `rst_o` high). The stretch counter starts full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_i | input | 1 | Synchronous active-high block reset |
| supply_ok_i | input | 1 | Supply-good flag from comparator, high = supply valid (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, active low (asynchronous) |
| rst_n_o | output | 1 | Registered active-low reset |
| rst_o | output | 1 | Registered active-high reset, inverse of rst_n_o |

## Verification
The bench first tries a lone supply dip and a lone manual press. Their exact rise latencies differ by the one extra cycle of the qualifier, so a misplaced stage or an off-by-one in the stretch shows up. Manual pulses one sample shorter than FILT and exactly FILT long separate correct glitch rejection from a filter that is too loose or too strict. A cause that comes back partway through a stretch shows whether the counter reloads or merely pauses. A long pseudo-random mix of overlapping supply dips and presses is compared every cycle against a behavioural model, to catch interactions the directed cases miss.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;

  // Stretch length in clock cycles from clock rate and wall time in microseconds.
  function automatic longint stretch_cycles(input longint clk_hz, input longint dur_us);
    return (clk_hz * dur_us) / 64'd1_000_000;
  endfunction

  // Minimum qualified low run in clock cycles, rounded up, never below one.
  function automatic int filt_cycles(input longint clk_hz, input longint min_ns);
    longint c;
    c = (clk_hz * min_ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  // Counter width able to hold 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int  W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/srg_mr_filter.sv
module srg_mr_filter #(
  parameter int FILT = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic mr_n_i,
  output logic mr_act_o
);
  logic act_q;

  generate
    if (FILT <= 1) begin : g_direct
      always_ff @(posedge clk_i) begin
        if (rst_i) act_q <= 1'b0;
        else       act_q <= ~mr_n_i;
      end
    end else begin : g_count
      localparam int FW = $clog2(FILT);
      localparam logic [FW-1:0] RUN_LAST = FW'(FILT - 1);
      logic [FW-1:0] run_q;

      always_ff @(posedge clk_i) begin
        if (rst_i || mr_n_i) begin
          run_q <= '0;
          act_q <= 1'b0;
        end else if (run_q == RUN_LAST) begin
          act_q <= 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  endgenerate

  assign mr_act_o = act_q;
endmodule

// File: rtl/srg_stretch.sv
module srg_stretch #(
  parameter int S  = 16,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          hold_i,
  output logic          rst_n_o,
  output logic          rst_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(S);

  logic [CW-1:0] cnt_q;
  logic          active;
  logic          rst_n_q;
  logic          rst_q;

  always_comb active = hold_i || (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= FULL;
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      if (hold_i)             cnt_q <= FULL;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      rst_n_q <= ~active;
      rst_q   <= active;
    end
  end

  assign rst_n_o = rst_n_q;
  assign rst_o   = rst_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_reset_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int STRETCH_US = 200_000,
  parameter int MR_MIN_NS  = 150
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int STRETCH_CYC = int'(stretch_cycles(longint'(CLK_HZ), longint'(STRETCH_US)));
  localparam int FILT_CYC    = filt_cycles(longint'(CLK_HZ), longint'(MR_MIN_NS));
  localparam int CW          = cnt_width(STRETCH_CYC);

  logic          sup_s;
  logic          mr_s;
  logic          mr_act;
  logic          hold;
  logic [CW-1:0] stretch_cnt;

  // Supply flag resets to "bad", manual request to "idle".
  srg_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sup (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(supply_ok_i), .q_o(sup_s)
  );

  srg_sync #(.W(1), .RST_VAL(1'b1)) u_sync_mr (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(mr_n_i), .q_o(mr_s)
  );

  srg_mr_filter #(.FILT(FILT_CYC)) u_filt (
    .clk_i(clk_i), .rst_i(rst_i), .mr_n_i(mr_s), .mr_act_o(mr_act)
  );

  always_comb hold = ~sup_s | mr_act;

  srg_stretch #(.S(STRETCH_CYC), .CW(CW)) u_stretch (
    .clk_i(clk_i), .rst_i(rst_i), .hold_i(hold),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .cnt_o(stretch_cnt)
  );
endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int S  = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          supply_ok_i,
  input logic          rst_n_o,
  input logic          rst_o,
  input logic          hold,
  input logic          mr_act,
  input logic          mr_s,
  input logic [CW-1:0] cnt
);
  // R6
  inv_pair_chk: assert property (@(posedge clk) disable iff (rst) rst_o == !rst_n_o);

  // R1
  sup_bad_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_ok_i, 3) |-> !rst_n_o);

  // R2
  mr_assert_chk: assert property (@(posedge clk) disable iff (rst) mr_act |=> !rst_n_o);

  // R7
  mr_qual_chk: assert property (@(posedge clk) disable iff (rst) $rose(mr_act) |-> !$past(mr_s));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst) hold |=> cnt == CW'(S));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(S));

  // R3
  rise_sup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(supply_ok_i, 3));

  // R9
  por_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !rst_n_o && rst_o);
endmodule

bind sup_reset_gen sup_reset_gen_chk #(.S(STRETCH_CYC), .CW(CW)) u_chk (
  .clk(clk_i), .rst(rst_i), .supply_ok_i(supply_ok_i),
  .rst_n_o(rst_n_o), .rst_o(rst_o), .hold(hold), .mr_act(mr_act),
  .mr_s(mr_s), .cnt(stretch_cnt)
);

// File: tb/sup_reset_gen_tb.sv
`timescale 1ns/1ps
module sup_reset_gen_tb;
  localparam int PERIOD   = 100;
  localparam int CLK_HZ   = 10_000_000;
  localparam int STR_US   = 5;
  localparam int MIN_NS   = 300;
  localparam int S        = CLK_HZ / 1_000_000 * STR_US; // R5: 50 cycles
  localparam int FILT     = 3;                           // ceil(10e6*300e-9)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic mr_n = 1'b1;
  logic rst_n_o, rst_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R9 power-on";

  always #(PERIOD/2) clk = ~clk;

  sup_reset_gen #(.CLK_HZ(CLK_HZ), .STRETCH_US(STR_US), .MR_MIN_NS(MIN_NS)) u_dut (
    .clk_i(clk), .rst_i(rst), .supply_ok_i(supply_ok), .mr_n_i(mr_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: low-run lengths and quiet-cycle count.
  int lr0, lr1, lr2, q;
  bit sp0, sp1, exp_now, exp_next, hold_m;
  always @(posedge clk) begin
    if (rst) begin
      lr0 = 0; lr1 = 0; lr2 = 0; sp0 = 0; sp1 = 0; q = 0;
      exp_now = 1; exp_next = 1;
    end else begin
      exp_now = exp_next;
      lr2 = lr1; lr1 = lr0;
      lr0 = mr_n ? 0 : ((lr0 < 1000) ? lr0 + 1 : lr0);
      sp1 = sp0; sp0 = supply_ok;
      hold_m = !sp1 || (lr2 >= FILT);
      q = hold_m ? 0 : ((q < 100000) ? q + 1 : q);
      exp_next = (q <= S);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(phase, rst_n_o, !exp_now);
      check("R6 inverse", rst_o, !rst_n_o);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_rise(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!rst_n_o && n < 2000);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 60000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
    end
  end

  initial begin
    int n;
    bit low_seen;
    logic [15:0] lfsr;
    tick(8);
    check("R9 reset rst_n_o", rst_n_o, 0);
    check("R9 reset rst_o", rst_o, 1);
    rst = 1'b0;
    tick(1);
    check("R9 after release", rst_n_o, 0);

    phase = "R1 supply bad";
    tick(10);
    check("R1 held", rst_n_o, 0);

    phase = "R3 supply recover";
    supply_ok = 1'b1;
    measure_rise(n);
    check("R3 rise edge", n, S + 3);
    tick(10);

    phase = "R2 manual press";
    mr_n = 1'b0;
    tick(6);
    check("R2 asserted", rst_n_o, 0);
    phase = "R4 manual release";
    mr_n = 1'b1;
    measure_rise(n);
    check("R4 rise edge", n, S + 4);
    tick(10);

    phase = "R7 short pulse";
    mr_n = 1'b0; tick(FILT - 1); mr_n = 1'b1;
    low_seen = 0;
    for (int i = 0; i < 12; i++) begin tick(1); if (!rst_n_o) low_seen = 1; end
    check("R7 short ignored", low_seen, 0);

    phase = "R2 min pulse";
    mr_n = 1'b0; tick(FILT); mr_n = 1'b1;
    low_seen = 0;
    for (int i = 0; i < 8; i++) begin tick(1); if (!rst_n_o) low_seen = 1; end
    check("R2 min pulse seen", low_seen, 1);
    tick(S + 10);

    phase = "R8 reload";
    supply_ok = 1'b0; tick(4); supply_ok = 1'b1;
    tick(20);
    check("R8 mid stretch", rst_n_o, 0);
    mr_n = 1'b0; tick(5);
    mr_n = 1'b1;
    measure_rise(n);
    check("R8 rise after reload", n, S + 4);
    tick(5);

    phase = "R8 mixed pattern";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[6:0] == 7'd0) supply_ok = ~supply_ok;
      if (lfsr[12:7] == 6'd5) mr_n = ~mr_n;
      if (lfsr[15:13] == 3'd0 && !mr_n) mr_n = 1'b1;
      tick(1);
    end
    supply_ok = 1'b1; mr_n = 1'b1;
    tick(S + 10);
    check("R3 final idle", rst_n_o, 1);
    finish_run();
  end
endmodule